// File: doc/BRIEF.md
# Calendar Clock with Update Cycle

This block keeps time of day and a calendar, stepping forward once per second from a slow tick enable (nominally 32768 Hz). The seconds, minutes, hours, weekday, day of month, month and two-digit year live in byte-wide registers that a host reads and writes over a simple single-cycle register port. All time fields share one number format, either packed decimal (tens digit in the upper nibble, units digit in the lower nibble) or plain binary. Hours are shown either on a 24-hour dial or on a 12-hour dial with a PM flag.

Two control registers steer the counting. The first holds a three-bit divider field and a read-only flag that warns the host that a seconds update is imminent. The second holds a freeze bit, the number-format bit and the hour-format bit. Counting runs only when the freeze bit is clear and the divider field selects a running code. One pair of divider codes holds the sub-second divider in reset. Leaving that state into a running code makes the first update occur after half a second. Interrupt flags, alarm matching and square-wave output belong to neighbouring blocks.

Top module: `rtc_calendar_clock`

## Requirements
- R1: After reset, addresses 0 to 8 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00, 0x26, 0x02. Address map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 control A, 8 control B. Addresses 9 to 15 read 0x00, and writes to them change nothing.
- R2: When counting runs, the seconds field advances once for every TICK_HZ cycles in which tick_en is high. Cycles with tick_en low do not count.
- R3: Counting runs only when control B bit 7 (freeze) is 0 and control A bits 6:4 hold 0, 1 or 2. Otherwise no field changes except by host writes, and the sub-second phase is held. Setting the freeze bit forces the update flag low. Clearing it resumes counting from the phase that was held.
- R4: When control A bits 6 and 5 are both 1, the sub-second divider is held at zero, no update occurs and the update flag reads 0.
- R5: A write to control A that leaves the divider-reset state with a running code in bits 6:4 schedules the first seconds update TICK_HZ/2 counted cycles after that write.
- R6: Control A bit 7 reads 1 during the final UIP_TICKS counted cycles before each seconds update, and reads 0 otherwise. A host write to bit 7 is ignored and does not disturb the phase.
- R7: Control B bit 2 selects the number format for every time field: 1 means binary, 0 means packed decimal.
- R8: Control B bit 1 selects the hour format. With 1, hours run 0 to 23. With 0, hours run 1 to 12, bit 7 is set for PM, and both midnight and noon read as 12.
- R9: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day fields. The weekday counts 1 to 7 and then returns to 1.
- R10: The day of month wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for the other long months, and for February 29 when the year is divisible by 4, else 28. A wrap carries into the month. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0.
- R11: A host write to a time field while counting runs is visible on the next read and leaves the sub-second phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle enable at the time-base rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |

## Verification
The bench builds the block with TICK_HZ = 64 and UIP_TICKS = 8, so one second lasts 64 counted cycles and the half-second release lasts 32. With this setting, the update-flag window, the phase kept across a freeze, and a seconds update after a paused time base can each be placed on an exact edge. Hundreds of updates fit in the run. The bench preloads times just before minute, day, month and year boundaries, in both number formats and both hour formats, so every carry chain is reached within a second of simulated time each.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned REG_SEC  = 0;
  localparam int unsigned REG_MIN  = 1;
  localparam int unsigned REG_HOUR = 2;
  localparam int unsigned REG_WDAY = 3;
  localparam int unsigned REG_MDAY = 4;
  localparam int unsigned REG_MON  = 5;
  localparam int unsigned REG_YEAR = 6;
  localparam int unsigned REG_CTLA = 7;
  localparam int unsigned REG_CTLB = 8;

  localparam int unsigned B_FREEZE = 7;
  localparam int unsigned B_BIN    = 2;
  localparam int unsigned B_H24    = 1;

  localparam logic [6:0] CTLA_RST = 7'h26;
  localparam logic [7:0] CTLB_RST = 8'h02;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] yr;
  } cal_regs_t;

  localparam cal_regs_t CAL_RST = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                    dow: 8'h01, dom: 8'h01, mon: 8'h01,
                                    yr: 8'h00};

  // Stored byte to plain number in the selected format.
  function automatic logic [6:0] raw_to_num(input logic [7:0] raw, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = {3'b000, raw[7:4]};
    ones = {3'b000, raw[3:0]};
    return bin ? raw[6:0] : 7'(tens * 7'd10) + ones;
  endfunction

  // Plain number (0..99) to stored byte in the selected format.
  function automatic logic [7:0] num_to_raw(input logic [6:0] n, input logic bin);
    return bin ? {1'b0, n} : {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  // Hour 0..23 to stored byte for the selected dial.
  function automatic logic [7:0] hour_to_raw(input logic [6:0] h, input logic bin,
                                             input logic h24);
    logic [6:0] h12;
    if (h24) return num_to_raw(h, bin);
    h12 = (h == 7'd0) ? 7'd12 : ((h > 7'd12) ? h - 7'd12 : h);
    return num_to_raw(h12, bin) | ((h >= 7'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICK_HZ   = 32768,
  parameter int unsigned UIP_TICKS = 8,
  parameter int unsigned CNT_W     = $clog2(TICK_HZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             div_rst,
  input  logic             half_ld,
  output logic [CNT_W-1:0] phase,
  output logic             sec_pulse,
  output logic             uip
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(TICK_HZ - 1);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(TICK_HZ / 2);
  localparam logic [CNT_W-1:0] UIP_FROM = CNT_W'(TICK_HZ - UIP_TICKS);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_d;
  logic             cnt_en;

  assign cnt_en = run && tick_en;

  // Release load outranks the held reset: it is written while reset is active.
  always_comb begin
    phase_d = phase_q;
    if (half_ld)       phase_d = HALF;
    else if (div_rst)  phase_d = '0;
    else if (cnt_en)   phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase     = phase_q;
  assign sec_pulse = cnt_en && (phase_q == LAST);
  assign uip       = run && (phase_q >= UIP_FROM);
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  cal_regs_t cur,
  input  logic      bin,
  input  logic      h24,
  output cal_regs_t nxt
);
  logic [6:0] s, m, h, hv, dw, dd, mo, yr, mlen;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s    = raw_to_num(cur.sec, bin);
    m    = raw_to_num(cur.min, bin);
    dw   = raw_to_num(cur.dow, bin);
    dd   = raw_to_num(cur.dom, bin);
    mo   = raw_to_num(cur.mon, bin);
    yr   = raw_to_num(cur.yr,  bin);
    hv   = raw_to_num({1'b0, cur.hr[6:0]}, bin);
    if (h24) begin
      h = raw_to_num(cur.hr, bin);
    end else begin
      h = (hv >= 7'd12) ? 7'd0 : hv;
      if (cur.hr[7]) h = h + 7'd12;
    end
    mlen = month_len(mo, yr);

    nxt   = cur;
    c_min = (s >= 7'd59);
    nxt.sec = num_to_raw(c_min ? 7'd0 : s + 7'd1, bin);

    c_hr = c_min && (m >= 7'd59);
    if (c_min) nxt.min = num_to_raw(c_hr ? 7'd0 : m + 7'd1, bin);

    c_day = c_hr && (h >= 7'd23);
    if (c_hr) nxt.hr = hour_to_raw(c_day ? 7'd0 : h + 7'd1, bin, h24);

    if (c_day) nxt.dow = num_to_raw((dw >= 7'd7) ? 7'd1 : dw + 7'd1, bin);

    c_mon = c_day && (dd >= mlen);
    if (c_day) nxt.dom = num_to_raw(c_mon ? 7'd1 : dd + 7'd1, bin);

    c_yr = c_mon && (mo >= 7'd12);
    if (c_mon) nxt.mon = num_to_raw(c_yr ? 7'd1 : mo + 7'd1, bin);

    if (c_yr) nxt.yr = num_to_raw((yr >= 7'd99) ? 7'd0 : yr + 7'd1, bin);
  end
endmodule

// File: rtl/rtc_calendar_clock.sv
module rtc_calendar_clock
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICK_HZ   = 32768,
  parameter int unsigned UIP_TICKS = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  localparam int unsigned CNT_W = $clog2(TICK_HZ);

  logic             rst_s_n;
  cal_regs_t        cal_q, cal_d, cal_nx;
  logic [6:0]       ctla_q, ctla_d;
  logic [7:0]       ctlb_q, ctlb_d;
  logic             run_w, div_rst_w, wr_a, half_ld, sec_pulse, uip_w;
  logic [CNT_W-1:0] phase_q;

  rtc_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s_n));

  assign run_w     = !ctlb_q[B_FREEZE] && (ctla_q[6:4] <= 3'd2);
  assign div_rst_w = (ctla_q[6:5] == 2'b11);
  assign wr_a      = wr_en && (addr == ADDR_W'(REG_CTLA));
  assign half_ld   = wr_a && div_rst_w && (wr_data[6:4] <= 3'd2);

  rtc_prescaler #(.TICK_HZ(TICK_HZ), .UIP_TICKS(UIP_TICKS), .CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_s_n), .tick_en(tick_en), .run(run_w),
    .div_rst(div_rst_w), .half_ld(half_ld), .phase(phase_q),
    .sec_pulse(sec_pulse), .uip(uip_w)
  );

  rtc_cal_step u_step (
    .cur(cal_q), .bin(ctlb_q[B_BIN]), .h24(ctlb_q[B_H24]), .nxt(cal_nx)
  );

  // Update first, then a host write to one field overrides that field only.
  always_comb begin
    cal_d  = sec_pulse ? cal_nx : cal_q;
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(REG_SEC):  cal_d.sec = wr_data;
        ADDR_W'(REG_MIN):  cal_d.min = wr_data;
        ADDR_W'(REG_HOUR): cal_d.hr  = wr_data;
        ADDR_W'(REG_WDAY): cal_d.dow = wr_data;
        ADDR_W'(REG_MDAY): cal_d.dom = wr_data;
        ADDR_W'(REG_MON):  cal_d.mon = wr_data;
        ADDR_W'(REG_YEAR): cal_d.yr  = wr_data;
        ADDR_W'(REG_CTLA): ctla_d    = wr_data[6:0];
        ADDR_W'(REG_CTLB): ctlb_d    = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cal_q  <= CAL_RST;
      ctla_q <= CTLA_RST;
      ctlb_q <= CTLB_RST;
    end else begin
      cal_q  <= cal_d;
      ctla_q <= ctla_d;
      ctlb_q <= ctlb_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_SEC):  rd_data = cal_q.sec;
      ADDR_W'(REG_MIN):  rd_data = cal_q.min;
      ADDR_W'(REG_HOUR): rd_data = cal_q.hr;
      ADDR_W'(REG_WDAY): rd_data = cal_q.dow;
      ADDR_W'(REG_MDAY): rd_data = cal_q.dom;
      ADDR_W'(REG_MON):  rd_data = cal_q.mon;
      ADDR_W'(REG_YEAR): rd_data = cal_q.yr;
      ADDR_W'(REG_CTLA): rd_data = {uip_w, ctla_q};
      ADDR_W'(REG_CTLB): rd_data = ctlb_q;
      default:           rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_clock_chk.sv
module rtc_calendar_clock_chk
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICK_HZ = 32768,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CNT_W   = $clog2(TICK_HZ)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              run,
  input logic              div_rst,
  input logic              uip,
  input logic              sec_pulse,
  input logic [CNT_W-1:0]  phase,
  input cal_regs_t         cal
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(TICK_HZ / 2);

  logic wr_ctla, wr_time, wr_sec;
  assign wr_ctla = wr_en && (addr == ADDR_W'(REG_CTLA));
  assign wr_time = wr_en && (addr <= ADDR_W'(REG_YEAR));
  assign wr_sec  = wr_en && (addr == ADDR_W'(REG_SEC));

  p_pulse_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (run && tick_en));

  p_sec_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_sec) |=> (cal.sec != $past(cal.sec)));

  p_cal_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_time) |=> $stable(cal));

  p_phase_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !div_rst) |=> $stable(phase));

  p_divrst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rst && !wr_ctla) |=> (phase == '0 && !uip));

  p_half_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rst && wr_ctla && (wr_data[6:4] <= 3'd2)) |=> (phase == HALF));

  p_uip_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> uip);
endmodule

bind rtc_calendar_clock rtc_calendar_clock_chk #(
  .TICK_HZ(TICK_HZ), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_s_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .run(run_w), .div_rst(div_rst_w), .uip(uip_w),
  .sec_pulse(sec_pulse), .phase(phase_q), .cal(cal_q)
);

// File: tb/rtc_calendar_clock_tb_top.sv
module rtc_calendar_clock_tb_top;
  localparam int unsigned TICK_HZ   = 64;
  localparam int unsigned UIP_TICKS = 8;
  localparam int unsigned ADDR_W    = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick_en;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int es, em, eh, ew, ed, emo, ey;
  bit ebin, eh24;

  always #10 clk = ~clk;

  rtc_calendar_clock #(.TICK_HZ(TICK_HZ), .UIP_TICKS(UIP_TICKS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] enc(int v, bit bin);
    if (bin) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hr(int h, bit bin, bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(int mo, int yr);
    case (mo)
      2:           return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(int a, logic [7:0] d);
    wr_en = 1'b1; addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    addr = ADDR_W'(a);
    #1;
    d = rd_data;
  endtask

  task automatic adv(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bump();
    es++;
    if (es == 60) begin
      es = 0; em++;
      if (em == 60) begin
        em = 0; eh++;
        if (eh == 24) begin
          eh = 0;
          ew = (ew == 7) ? 1 : ew + 1;
          ed++;
          if (ed > mdays(emo, ey)) begin
            ed = 1; emo++;
            if (emo == 13) begin emo = 1; ey = (ey + 1) % 100; end
          end
        end
      end
    end
  endtask

  // Divider held in reset while the time and the formats are loaded.
  task automatic load(int s, int m, int h, int w, int d, int mo, int y, bit bin, bit h24);
    es = s; em = m; eh = h; ew = w; ed = d; emo = mo; ey = y; ebin = bin; eh24 = h24;
    wr(7, 8'h66);
    wr(8, {5'b0, bin, h24, 1'b0});
    wr(0, enc(s, bin));
    wr(1, enc(m, bin));
    wr(2, enc_hr(h, bin, h24));
    wr(3, enc(w, bin));
    wr(4, enc(d, bin));
    wr(5, enc(mo, bin));
    wr(6, enc(y, bin));
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    rd(0, v); chk(tag, v, enc(es, ebin));
    rd(1, v); chk(tag, v, enc(em, ebin));
    rd(2, v); chk(tag, v, enc_hr(eh, ebin, eh24));
    rd(3, v); chk(tag, v, enc(ew, ebin));
    rd(4, v); chk(tag, v, enc(ed, ebin));
    rd(5, v); chk(tag, v, enc(emo, ebin));
    rd(6, v); chk(tag, v, enc(ey, ebin));
  endtask

  // Release the divider (R5: update 32 counted edges later), then compare.
  task automatic step_case(int s, int m, int h, int w, int d, int mo, int y,
                           bit bin, bit h24, string tag);
    logic [7:0] v;
    load(s, m, h, w, d, mo, y, bin, h24);
    wr(7, 8'h26);
    adv(31);
    rd(0, v); chk({tag, " R5 half-second hold"}, v, enc(s, bin));
    adv(1);
    bump();
    check_all(tag);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0; addr = '0; wr_data = 8'h00;
    adv(3);
    rst_n = 1'b1;
    adv(3);

    // R1: reset contents and unmapped addresses
    rd(0, v); chk("R1 seconds", v, 8'h00);
    rd(1, v); chk("R1 minutes", v, 8'h00);
    rd(2, v); chk("R1 hours", v, 8'h00);
    rd(3, v); chk("R1 weekday", v, 8'h01);
    rd(4, v); chk("R1 mday", v, 8'h01);
    rd(5, v); chk("R1 month", v, 8'h01);
    rd(6, v); chk("R1 year", v, 8'h00);
    rd(7, v); chk("R1 ctrl A", v, 8'h26);
    rd(8, v); chk("R1 ctrl B", v, 8'h02);
    wr(9, 8'hFF);
    rd(9, v); chk("R1 unmapped read", v, 8'h00);
    rd(8, v); chk("R1 unmapped write", v, 8'h02);

    // R4: divider reset holds everything, flag low
    load(10, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
    adv(100);
    rd(0, v); chk("R4 no update in divider reset", v, 8'h10);
    rd(7, v); chk("R4 flag low in divider reset", v, 8'h66);

    // R5 + R6: release, flag window, write to flag bit ignored
    wr(7, 8'h26);                  // phase 32
    adv(2);                        // 34
    wr(7, 8'hA6);                  // counted edge -> 35
    rd(7, v); chk("R6 flag bit write ignored", v, 8'h26);
    adv(20);                       // 55
    rd(7, v); chk("R6 flag low before window", v[7], 1'b0);
    adv(1);                        // 56
    rd(7, v); chk("R6 flag high in window", v[7], 1'b1);
    adv(7);                        // 63
    rd(7, v); chk("R6 flag high at last cycle", v[7], 1'b1);
    rd(0, v); chk("R6 no update yet", v, 8'h10);
    adv(1);
    rd(7, v); chk("R6 flag low after update", v[7], 1'b0);
    rd(0, v); chk("R2 R5 seconds advanced", v, 8'h11);

    // R3: freeze keeps phase, clears flag
    load(20, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
    wr(7, 8'h26);                  // 32
    adv(25);                       // 57
    rd(7, v); chk("R3 flag high before freeze", v[7], 1'b1);
    wr(8, 8'h82);                  // counted edge -> 58, frozen
    rd(7, v); chk("R3 freeze clears flag", v[7], 1'b0);
    adv(50);
    rd(0, v); chk("R3 frozen seconds hold", v, 8'h20);
    wr(8, 8'h02);                  // not counted, phase 58
    rd(7, v); chk("R3 flag back after resume", v[7], 1'b1);
    adv(5);                        // 63
    rd(0, v); chk("R3 phase kept, no update yet", v, 8'h20);
    adv(1);
    rd(0, v); chk("R3 update after resumed phase", v, 8'h21);

    // R3: non-running divider code stops counting
    wr(7, 8'h46);
    adv(100);
    rd(0, v); chk("R3 stopped divider code", v, 8'h21);
    rd(7, v); chk("R3 flag low when stopped", v, 8'h46);

    // R2: tick enable gates counting
    load(30, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
    wr(7, 8'h26);
    tick_en = 1'b0;
    adv(40);
    tick_en = 1'b1;
    adv(31);
    rd(0, v); chk("R2 idle ticks not counted", v, 8'h30);
    adv(1);
    rd(0, v); chk("R2 update after enabled ticks", v, 8'h31);

    // R11: write while running keeps phase
    load(10, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
    wr(7, 8'h26);                  // 32
    adv(5);                        // 37
    wr(1, 8'h42);                  // counted -> 38
    rd(1, v); chk("R11 written minutes visible", v, 8'h42);
    adv(25);
    rd(0, v); chk("R11 phase kept, no update", v, 8'h10);
    adv(1);
    rd(0, v); chk("R11 update on original phase", v, 8'h11);
    rd(1, v); chk("R11 written minutes kept", v, 8'h42);

    // Directed rollovers
    step_case(59, 59, 23, 7, 31, 12, 99, 1'b0, 1'b1, "R9 R10 year wrap");
    step_case(59, 59, 23, 3, 28, 2, 23, 1'b1, 1'b1, "R10 R7 non-leap Feb");
    step_case(59, 59, 23, 3, 28, 2, 24, 1'b0, 1'b1, "R10 leap Feb 28");
    step_case(59, 59, 23, 4, 29, 2, 24, 1'b1, 1'b1, "R10 leap Feb 29");
    step_case(59, 59, 23, 5, 30, 4, 50, 1'b0, 1'b1, "R10 30-day month");
    step_case(59, 59, 23, 2, 15, 6, 10, 1'b0, 1'b0, "R8 PM to midnight");
    step_case(59, 59, 11, 2, 15, 6, 10, 1'b1, 1'b0, "R8 R7 AM to noon");
    step_case(59, 59, 12, 2, 15, 6, 10, 1'b0, 1'b0, "R8 noon to 1 PM");
    step_case(59, 59, 9, 6, 15, 6, 10, 1'b1, 1'b1, "R9 R7 hour carry");

    // Random cases
    for (int i = 0; i < 40; i++) begin
      int s, m, h, w, d, mo, y;
      bit bin, h24;
      mo  = 1 + int'($urandom % 12);
      y   = int'($urandom % 100);
      d   = 1 + int'($urandom % mdays(mo, y));
      h   = int'($urandom % 24);
      m   = int'($urandom % 60);
      s   = int'($urandom % 60);
      w   = 1 + int'($urandom % 7);
      if ($urandom % 2 == 0) s = 59;
      if ($urandom % 3 == 0) m = 59;
      if ($urandom % 3 == 0) h = 23;
      if ($urandom % 3 == 0) d = mdays(mo, y);
      bin = 1'($urandom % 2);
      h24 = 1'($urandom % 2);
      step_case(s, m, h, w, d, mo, y, bin, h24, "R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule